// File: doc/BRIEF.md
# Stereo Attenuator with Soft Mute

This block is the per-sample gain stage in front of a stereo audio conversion path. Once per frame a strobe presents one left and one right two's-complement sample. Each channel is scaled by its own unsigned linear volume word. The result is rounded, can be negated for an inverting output stage, is saturated back to the sample width, and is held on registered outputs until the next frame.

Volume and mute changes never jump the applied gain. A per-channel effective gain walks toward its target by a fixed increment once per frame. A mute request from the control bit or from the external pin sets that target to zero for both channels, so the output fades out. When mute is released, the output fades back in. A silence detector watches the raw inputs and raises a flag once both channels have been zero for long enough.

Top module: `stereo_atten`

## Requirements
- R1: After reset both outputs and the zero flag are 0. The effective gain of both channels is unity, so the first frame passes its samples unchanged.
- R2: The output is floor((sample * gain + 8192) / 16384), where gain is the effective gain in units of 1/16384. Halves therefore round toward plus infinity: 1.5 gives 2 and -1.5 gives -1. The output is registered and appears in the cycle after the frame strobe.
- R3: A volume word of 16383 (all ones) targets unity gain (16384), so a full-scale sample passes unchanged. Any other word v targets gain v.
- R4: On each frame the effective gain moves toward its target by GAIN_STEP (default 256) and lands exactly on the target when it is closer than that. A frame's output uses the gain held before that frame's update.
- R5: When mute_reg_i or mute_pin_i is high, the target of both channels is 0 and the gain ramps down to 0, which silences the outputs. When mute is released, the gain ramps back to the volume target.
- R6: When invert_i is high at a frame, both outputs are negated after scaling. The code -8388608 negates to the saturated value 8388607.
- R7: zero_o rises on the 1025th consecutive frame in which both input samples are 0.
- R8: A frame with a nonzero sample on either channel clears zero_o and the silence count at that same frame.
- R9: Outputs, zero flag and effective gains change only at frame strobes. Input changes without a strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle sample strobe at the frame rate |
| left_i | input | 24 | Left input sample, two's complement |
| right_i | input | 24 | Right input sample, two's complement |
| vol_l_i | input | 14 | Left volume word, unsigned linear |
| vol_r_i | input | 14 | Right volume word, unsigned linear |
| mute_reg_i | input | 1 | Mute request from the control register |
| mute_pin_i | input | 1 | Mute request from the external pin, active high |
| invert_i | input | 1 | Output phase inversion |
| left_o | output | 24 | Left scaled sample |
| right_o | output | 24 | Right scaled sample |
| zero_o | output | 1 | Both channels silent for more than 1024 frames |

## Verification
The hardest states to reach are the middle of a gain ramp and the exact edge of the silence window. A ramp is only visible through the outputs, one frame at a time. The bench keeps its own model of each channel's effective gain, steps it on every strobe, and checks every output during volume changes, mute fades and releases. For the zero flag, the bench drives exactly 1024 silent frames and checks that the flag is still low. It then checks the rise on the next frame, breaks the run with a single nonzero sample, and repeats the count to show that the counter restarted.

// File: rtl/stereo_atten_pkg.sv
package stereo_atten_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int VOLUME_W   = 14;
  localparam int CHANNELS   = 2;
  localparam int RAMP_STEP  = 256;
  localparam int SILENT_LEN = 1024;

  typedef enum logic [0:0] {CH_LEFT = 1'b0, CH_RIGHT = 1'b1} chan_e;
endpackage

// File: rtl/gain_ramp.sv
module gain_ramp #(
  parameter int VOL_W = 14,
  parameter int STEP  = 256,
  localparam int GW   = VOL_W + 1,
  localparam int UNITY = 1 << VOL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             mute_i,
  input  logic [VOL_W-1:0] vol_i,
  output logic [GW-1:0]    gain_o
);
  localparam logic [GW-1:0] UNITY_G = GW'(UNITY);
  localparam logic [GW-1:0] STEP_G  = GW'(STEP);

  logic [GW-1:0] target, gain_q, gain_d;

  // all-ones volume maps to exact unity
  always_comb begin
    if (mute_i)              target = '0;
    else if (&vol_i)         target = UNITY_G;
    else                     target = {1'b0, vol_i};
  end

  always_comb begin
    gain_d = gain_q;
    if (gain_q < target) begin
      if (target - gain_q > STEP_G) gain_d = gain_q + STEP_G;
      else                          gain_d = target;
    end else if (gain_q > target) begin
      if (gain_q - target > STEP_G) gain_d = gain_q - STEP_G;
      else                          gain_d = target;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gain_q <= UNITY_G;
    else if (frame_i) gain_q <= gain_d;
  end

  assign gain_o = gain_q;
endmodule

// File: rtl/sample_scaler.sv
module sample_scaler #(
  parameter int DW    = 24,
  parameter int VOL_W = 14,
  localparam int GW   = VOL_W + 1,
  localparam int PW   = DW + GW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_i,
  input  logic signed [DW-1:0] sample_i,
  input  logic [GW-1:0]        gain_i,
  input  logic                 invert_i,
  output logic signed [DW-1:0] sample_o
);
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (VOL_W - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DW - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINV = -(PW'(1) <<< (DW - 1));

  logic signed [PW-1:0] prod, rnd, scl, sgn;
  logic signed [DW-1:0] sat, out_q;

  always_comb begin
    prod = PW'(sample_i) * PW'($signed({1'b0, gain_i}));
    rnd  = prod + HALF;
    scl  = rnd >>> VOL_W;
    sgn  = invert_i ? -scl : scl;
    if (sgn > MAXV)      sat = MAXV[DW-1:0];
    else if (sgn < MINV) sat = MINV[DW-1:0];
    else                 sat = sgn[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (frame_i) out_q <= sat;
  end

  assign sample_o = out_q;
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
  parameter int LEN = 1024,
  localparam int CW = $clog2(LEN + 2)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic silent_i,
  output logic zero_o
);
  localparam logic [CW-1:0] LAST = CW'(LEN);

  logic [CW-1:0] cnt_q;
  logic          flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (frame_i) begin
      if (!silent_i) begin
        cnt_q  <= '0;
        flag_q <= 1'b0;
      end else if (cnt_q >= LAST) begin
        flag_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign zero_o = flag_q;
endmodule

// File: rtl/stereo_atten.sv
module stereo_atten
  import stereo_atten_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int VOL_W = VOLUME_W,
  parameter int STEP  = RAMP_STEP,
  parameter int ZLEN  = SILENT_LEN,
  localparam int GW   = VOL_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_i,
  input  logic signed [DW-1:0] left_i,
  input  logic signed [DW-1:0] right_i,
  input  logic [VOL_W-1:0]     vol_l_i,
  input  logic [VOL_W-1:0]     vol_r_i,
  input  logic                 mute_reg_i,
  input  logic                 mute_pin_i,
  input  logic                 invert_i,
  output logic signed [DW-1:0] left_o,
  output logic signed [DW-1:0] right_o,
  output logic                 zero_o
);
  logic                 mute_any;
  logic signed [DW-1:0] smp_in  [CHANNELS];
  logic signed [DW-1:0] smp_out [CHANNELS];
  logic [VOL_W-1:0]     vol     [CHANNELS];
  logic [GW-1:0]        gain    [CHANNELS];
  logic [GW-1:0]        gain_l, gain_r;

  assign mute_any       = mute_reg_i | mute_pin_i;
  assign smp_in[CH_LEFT]  = left_i;
  assign smp_in[CH_RIGHT] = right_i;
  assign vol[CH_LEFT]     = vol_l_i;
  assign vol[CH_RIGHT]    = vol_r_i;

  for (genvar g = 0; g < CHANNELS; g++) begin : g_ch
    gain_ramp #(.VOL_W(VOL_W), .STEP(STEP)) ramp_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .frame_i (frame_i),
      .mute_i  (mute_any),
      .vol_i   (vol[g]),
      .gain_o  (gain[g])
    );
    sample_scaler #(.DW(DW), .VOL_W(VOL_W)) scale_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .frame_i  (frame_i),
      .sample_i (smp_in[g]),
      .gain_i   (gain[g]),
      .invert_i (invert_i),
      .sample_o (smp_out[g])
    );
  end

  zero_detect #(.LEN(ZLEN)) zdet_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_i  (frame_i),
    .silent_i ((left_i == '0) && (right_i == '0)),
    .zero_o   (zero_o)
  );

  assign gain_l  = gain[CH_LEFT];
  assign gain_r  = gain[CH_RIGHT];
  assign left_o  = smp_out[CH_LEFT];
  assign right_o = smp_out[CH_RIGHT];
endmodule

// File: rtl/stereo_atten_chk.sv
module stereo_atten_chk #(
  parameter int DW    = 24,
  parameter int VOL_W = 14,
  parameter int STEP  = 256,
  localparam int GW   = VOL_W + 1,
  localparam int UNITY = 1 << VOL_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_i,
  input logic [DW-1:0] left_i,
  input logic [DW-1:0] right_i,
  input logic [DW-1:0] left_o,
  input logic [DW-1:0] right_o,
  input logic          zero_o,
  input logic          mute_i,
  input logic [GW-1:0] gain_l_i,
  input logic [GW-1:0] gain_r_i
);
  // R1
  gain_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gain_l_i) <= UNITY && int'(gain_r_i) <= UNITY);

  // R4
  ramp_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> ((int'(gain_l_i) - int'($past(gain_l_i))) <= STEP) &&
                ((int'($past(gain_l_i)) - int'(gain_l_i)) <= STEP) &&
                ((int'(gain_r_i) - int'($past(gain_r_i))) <= STEP) &&
                ((int'($past(gain_r_i)) - int'(gain_r_i)) <= STEP));

  // R5
  mute_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && mute_i |=> gain_l_i <= $past(gain_l_i) && gain_r_i <= $past(gain_r_i));

  // R5
  mute_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && gain_l_i == '0 && gain_r_i == '0 |=> left_o == '0 && right_o == '0);

  // R7
  zero_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(zero_o) |-> $past(frame_i && left_i == '0 && right_i == '0));

  // R8
  zero_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i && (left_i != '0 || right_i != '0) |=> !zero_o);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> $stable(left_o) && $stable(right_o) && $stable(zero_o) &&
                 $stable(gain_l_i) && $stable(gain_r_i));
endmodule

bind stereo_atten stereo_atten_chk #(.DW(DW), .VOL_W(VOL_W), .STEP(STEP)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .frame_i  (frame_i),
  .left_i   (left_i),
  .right_i  (right_i),
  .left_o   (left_o),
  .right_o  (right_o),
  .zero_o   (zero_o),
  .mute_i   (mute_any),
  .gain_l_i (gain_l),
  .gain_r_i (gain_r)
);

// File: tb/stereo_atten_tb_top.sv
`timescale 1ns/1ps
module stereo_atten_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame = 1'b0;
  logic signed [23:0] l_in = '0, r_in = '0;
  logic [13:0] vol_l = 14'h3fff, vol_r = 14'h3fff;
  logic mute_reg = 1'b0, mute_pin = 1'b0, inv = 1'b0;
  logic signed [23:0] l_out, r_out;
  logic zero;

  int errors = 0;
  int checks = 0;
  int gm_l = 16384, gm_r = 16384;
  longint exp_l, exp_r;

  always #4 clk = ~clk;

  stereo_atten dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame),
    .left_i(l_in), .right_i(r_in), .vol_l_i(vol_l), .vol_r_i(vol_r),
    .mute_reg_i(mute_reg), .mute_pin_i(mute_pin), .invert_i(inv),
    .left_o(l_out), .right_o(r_out), .zero_o(zero)
  );

  typedef struct packed {
    logic signed [23:0] l, r;
    logic               iv;
    logic signed [23:0] el, er;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{24'sd8388607, -24'sd8388608, 1'b0, 24'sd8388607, -24'sd8388608},
    '{24'sd100, -24'sd100, 1'b0, 24'sd100, -24'sd100},
    '{24'sd8388607, -24'sd8388608, 1'b1, -24'sd8388607, 24'sd8388607},
    '{24'sd5, -24'sd7, 1'b1, -24'sd5, 24'sd7},
    '{24'sd0, 24'sd1, 1'b0, 24'sd0, 24'sd1},
    '{-24'sd1, 24'sd123456, 1'b1, 24'sd1, -24'sd123456}
  };

  function automatic longint model_out(longint x, int g, logic iv);
    longint p = (x * g + 8192) >>> 14;
    if (iv) p = -p;
    if (p > 8388607) p = 8388607;
    if (p < -8388608) p = -8388608;
    return p;
  endfunction

  function automatic int model_step(int g, logic [13:0] v, logic m);
    int t = m ? 0 : ((v == 14'h3fff) ? 16384 : int'(v));
    if (g < t) return (t - g > 256) ? g + 256 : t;
    if (g > t) return (g - t > 256) ? g - 256 : t;
    return g;
  endfunction

  task automatic check_val(string req, longint act, longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_frame(logic signed [23:0] l, logic signed [23:0] r);
    @(negedge clk);
    l_in = l; r_in = r; frame = 1'b1;
    exp_l = model_out(longint'(l), gm_l, inv);
    exp_r = model_out(longint'(r), gm_r, inv);
    gm_l = model_step(gm_l, vol_l, mute_reg | mute_pin);
    gm_r = model_step(gm_r, vol_r, mute_reg | mute_pin);
    @(negedge clk);
    frame = 1'b0;
  endtask

  task automatic frame_chk(logic signed [23:0] l, logic signed [23:0] r, string req);
    run_frame(l, r);
    check_val(req, longint'(l_out), exp_l);
    check_val(req, longint'(r_out), exp_r);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_val("R1", longint'(l_out), 0);
    check_val("R1", longint'(r_out), 0);
    check_val("R1", longint'(zero), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R6: table at unity gain
    foreach (VECS[i]) begin
      inv = VECS[i].iv;
      run_frame(VECS[i].l, VECS[i].r);
      check_val(i == 0 ? "R1" : "R6", longint'(l_out), longint'(VECS[i].el));
      check_val(i == 0 ? "R3" : "R6", longint'(r_out), longint'(VECS[i].er));
    end
    inv = 1'b0;

    // R4 ramp from unity toward half and quarter
    vol_l = 14'd8192; vol_r = 14'd4096;
    run_frame(24'sd1000, -24'sd1000);
    check_val("R4", longint'(l_out), 1000);
    run_frame(24'sd1000, -24'sd1000);
    check_val("R4", longint'(l_out), 984);
    for (int k = 0; k < 60; k++) frame_chk(24'sd1000, -24'sd1000, "R4");
    // R2 settled gain and rounding
    run_frame(24'sd1000, -24'sd1000);
    check_val("R2", longint'(l_out), 500);
    check_val("R2", longint'(r_out), -250);
    run_frame(24'sd3, 24'sd3);
    check_val("R2", longint'(l_out), 2);
    check_val("R2", longint'(r_out), 1);
    run_frame(-24'sd3, -24'sd3);
    check_val("R2", longint'(l_out), -1);
    check_val("R2", longint'(r_out), -1);

    // R3 back to full scale
    vol_l = 14'h3fff; vol_r = 14'h3fff;
    for (int k = 0; k < 60; k++) frame_chk(24'sd4321, -24'sd4321, "R4");
    run_frame(24'sd8388607, -24'sd8388608);
    check_val("R3", longint'(l_out), 8388607);
    check_val("R3", longint'(r_out), -8388608);

    // R5 register mute fade and release
    mute_reg = 1'b1;
    for (int k = 0; k < 70; k++) frame_chk(24'sd8388607, -24'sd777, "R5");
    check_val("R5", longint'(l_out), 0);
    check_val("R5", longint'(r_out), 0);
    mute_reg = 1'b0;
    for (int k = 0; k < 70; k++) frame_chk(24'sd8388607, -24'sd777, "R5");
    check_val("R5", longint'(l_out), 8388607);
    // R5 pin mute
    mute_pin = 1'b1;
    for (int k = 0; k < 70; k++) frame_chk(-24'sd5000, 24'sd5000, "R5");
    check_val("R5", longint'(r_out), 0);
    mute_pin = 1'b0;
    for (int k = 0; k < 70; k++) frame_chk(-24'sd5000, 24'sd5000, "R5");
    check_val("R5", longint'(r_out), 5000);

    // R9 no strobe, inputs move
    @(negedge clk);
    l_in = 24'sd77; r_in = 24'sd0; inv = 1'b1; vol_l = 14'd1; mute_reg = 1'b1;
    repeat (5) @(negedge clk);
    check_val("R9", longint'(l_out), -5000);
    check_val("R9", longint'(r_out), 5000);
    inv = 1'b0; vol_l = 14'h3fff; mute_reg = 1'b0;
    frame_chk(24'sd77, 24'sd88, "R9");
    check_val("R9", longint'(l_out), 77);

    // R7 R8 silence window
    for (int k = 0; k < 1024; k++) run_frame(24'sd0, 24'sd0);
    check_val("R7", longint'(zero), 0);
    run_frame(24'sd0, 24'sd0);
    check_val("R7", longint'(zero), 1);
    run_frame(24'sd0, 24'sd5);
    check_val("R8", longint'(zero), 0);
    for (int k = 0; k < 1024; k++) run_frame(24'sd0, 24'sd0);
    check_val("R8", longint'(zero), 0);
    run_frame(24'sd0, 24'sd0);
    check_val("R7", longint'(zero), 1);
    run_frame(-24'sd1, 24'sd0);
    check_val("R8", longint'(zero), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule